// File: doc/BRIEF.md
# Inbound Target Retry and Disconnect Controller

This block decides how a bridge answers, as a PCI-style bus target, when an inbound read or write reaches it. At the first data phase of a new access it chooses between accepting the access and signalling retry. When it chooses retry for a fresh read and a delayed-read slot is free, it also asks for that slot to be allocated. It bases that choice on four things: a lock held from the host side, a parallel compare against the delayed reads already in flight, whether a delayed-read slot is free, and the number of free posting slots.

During a burst, each data phase is checked on its own. Reads are cut short at the last word of a cacheline or when the burst does not use linear addressing. Writes are cut short when posting space runs out or when the next word would start a new line. All decisions are registered, so every strobe appears one clock after the inputs that caused it.

Top module: `tgt_resp_ctrl`

## Requirements
- R1: One cycle after `start` is high, exactly one of `acc` and `retry` is high. Without `start`, neither `acc`, `retry` nor `alloc` is raised. Reset (`rst_n` low, asynchronous) clears all outputs.
- R2: When `host_lock` is high, a started access of any command is retried with `alloc` low. This rule takes priority over every other one.
- R3: A read (`start_cmd` 2'b00) whose address and command both equal those of an entry with `dr_pend`=1 and `dr_ready`=0 is retried without allocation. This holds even when other entries are free.
- R4: A read that matches an entry with `dr_pend`=1 and `dr_ready`=1, and matches no waiting entry, is accepted.
- R5: A read that matches no pending entry is retried. If some entry has `dr_pend`=0, `alloc` is also raised and `alloc_idx` gives the lowest such index. If every entry is pending, `alloc` stays low.
- R6: A plain memory write (`start_cmd` 2'b01, and 2'b11 handled the same way) is accepted when `post_free` is at least 1 and retried otherwise.
- R7: A write-and-invalidate (`start_cmd` 2'b10) is accepted only when `post_free` is at least one full line of words (16 with the defaults). Otherwise it is retried.
- R8: For a read data phase (`phase`=1, `phase_write`=0), `disc` is raised one cycle later when `phase_linear` is 0, or when `phase_addr` is the last bus word of its 64-byte line (address bits [5:2] equal to 15).
- R9: For a write data phase, `disc` is raised one cycle later when `post_free` is 0 or 1, or when `phase_addr` is the last word of its line. `phase_linear` has no effect on writes. Without `phase`, `disc` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | First data phase of a new inbound access |
| start_addr | input | AW (32) | Address of the new access |
| start_cmd | input | 2 | Command: 00 read, 01 write, 10 write-and-invalidate, 11 write |
| host_lock | input | 1 | Interface locked from the host side |
| dr_pend | input | NDR (4) | Delayed-read slot holds a captured request |
| dr_ready | input | NDR (4) | Data for that slot has arrived |
| dr_addr | input | NDR*AW (128) | Slot addresses, slot i at bits [i*AW +: AW] |
| dr_cmd | input | NDR*2 (8) | Slot commands, slot i at bits [i*2 +: 2] |
| post_free | input | PW (8) | Free posting slots, in bus words |
| phase | input | 1 | A burst data phase is in progress |
| phase_addr | input | AW (32) | Address of the current data phase |
| phase_write | input | 1 | Current burst is a write |
| phase_linear | input | 1 | Burst uses linear addressing |
| acc | output | 1 | Access accepted |
| retry | output | 1 | Access retried |
| disc | output | 1 | Disconnect after this data phase |
| alloc | output | 1 | Allocate a delayed-read slot |
| alloc_idx | output | clog2(NDR) (2) | Slot to allocate |

## Verification
Two conditions are the hardest to reach from the ports. The first is a read whose address matches a slot exactly but whose command differs. The second is a waiting slot that overlaps free slots, because only the priority order then stops an allocation. The bench sweeps every combination of pending and ready masks with the target address placed in each slot in turn, with the slot's command deliberately changed, and with the address matching no slot at all. It crosses these with lock and with posting counts on both sides of the one-word and full-line thresholds. Burst phases are swept over every word offset in a line.

// File: rtl/tgt_resp_pkg.sv
package tgt_resp_pkg;

  typedef enum logic [1:0] {
    CMD_READ   = 2'd0,
    CMD_WRITE  = 2'd1,
    CMD_WINV   = 2'd2,
    CMD_WRITE2 = 2'd3
  } bus_cmd_e;

  // reason for the first-phase decision, brought out for assertions
  typedef enum logic [2:0] {
    WHY_IDLE,
    WHY_LOCKED,
    WHY_IN_FLIGHT,
    WHY_SERVED,
    WHY_NEW_READ,
    WHY_NO_SLOT,
    WHY_POSTED,
    WHY_NO_ROOM
  } why_e;

  function automatic logic [63:0] line_index(input logic [63:0] a, input int unsigned line_lg);
    return a >> line_lg;
  endfunction

  function automatic logic last_in_line(input logic [63:0] a, input int unsigned line_lg,
                                        input int unsigned step);
    return line_index(a + 64'(step), line_lg) != line_index(a, line_lg);
  endfunction

  function automatic logic room_for(input logic [1:0] cmd, input int unsigned free_slots,
                                    input int unsigned line_words);
    if (cmd == CMD_WINV) return free_slots >= line_words;
    return free_slots >= 1;
  endfunction

endpackage

// File: rtl/dt_match.sv
module dt_match #(
  parameter int AW  = 32,
  parameter int NDR = 4,
  parameter int IW  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     q_addr,
  input  logic [1:0]        q_cmd,
  input  logic [NDR-1:0]    ent_pend,
  input  logic [NDR-1:0]    ent_ready,
  input  logic [NDR*AW-1:0] ent_addr,
  input  logic [NDR*2-1:0]  ent_cmd,
  output logic              hit_wait,
  output logic              hit_done,
  output logic              free_any,
  output logic [IW-1:0]     free_idx
);
  logic [NDR-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < NDR; g++) begin : g_cmp
      assign hit[g] = ent_pend[g]
                   && (ent_addr[g*AW +: AW] == q_addr)
                   && (ent_cmd[g*2 +: 2] == q_cmd);
    end
  endgenerate

  assign hit_wait = |(hit & ~ent_ready);
  assign hit_done = |(hit & ent_ready);
  assign free_any = |(~ent_pend);

  always_comb begin
    free_idx = '0;
    for (int i = NDR - 1; i >= 0; i--) begin
      if (!ent_pend[i]) free_idx = IW'(i);
    end
  end

  // R5: the chosen slot is really free
  p_free_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    free_any |-> !ent_pend[free_idx]);

endmodule

// File: rtl/start_decide.sv
module start_decide
  import tgt_resp_pkg::*;
#(
  parameter int PW         = 8,
  parameter int LINE_WORDS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          lock,
  input  logic [1:0]    cmd,
  input  logic [PW-1:0] post_free,
  input  logic          hit_wait,
  input  logic          hit_done,
  input  logic          free_any,
  output why_e          why,
  output logic          acc_n,
  output logic          retry_n,
  output logic          alloc_n
);
  logic room;
  assign room = room_for(cmd, int'(post_free), LINE_WORDS);

  // fixed priority: lock, then in-flight match, then resources
  always_comb begin
    why = WHY_IDLE;
    if (start) begin
      if (lock)                    why = WHY_LOCKED;
      else if (cmd == CMD_READ) begin
        if (hit_wait)              why = WHY_IN_FLIGHT;
        else if (hit_done)         why = WHY_SERVED;
        else if (free_any)         why = WHY_NEW_READ;
        else                       why = WHY_NO_SLOT;
      end
      else if (room)               why = WHY_POSTED;
      else                         why = WHY_NO_ROOM;
    end
  end

  assign acc_n   = (why == WHY_SERVED) || (why == WHY_POSTED);
  assign alloc_n = (why == WHY_NEW_READ);
  assign retry_n = start && !acc_n;

  // R4: completed delayed read is handed over
  p_served_accepts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start && !lock && cmd == CMD_READ && !hit_wait && hit_done |-> acc_n);

  // R3: a waiting match never allocates
  p_wait_no_alloc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_wait && cmd == CMD_READ |-> !alloc_n);

endmodule

// File: rtl/phase_decide.sv
module phase_decide
  import tgt_resp_pkg::*;
#(
  parameter int AW         = 32,
  parameter int PW         = 8,
  parameter int LINE_BYTES = 64,
  parameter int BUS_BYTES  = 4
) (
  input  logic          phase,
  input  logic          write,
  input  logic          linear,
  input  logic [AW-1:0] addr,
  input  logic [PW-1:0] post_free,
  output logic          eol,
  output logic          post_low,
  output logic          disc_n
);
  localparam int unsigned LINE_LG = $clog2(LINE_BYTES);

  assign eol      = last_in_line(64'(addr), LINE_LG, BUS_BYTES);
  assign post_low = post_free <= PW'(1);
  assign disc_n   = phase && (write ? (post_low || eol) : (!linear || eol));

endmodule

// File: rtl/tgt_resp_ctrl.sv
module tgt_resp_ctrl
  import tgt_resp_pkg::*;
#(
  parameter int AW         = 32,
  parameter int NDR        = 4,
  parameter int PW         = 8,
  parameter int LINE_BYTES = 64,
  parameter int BUS_BYTES  = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                start,
  input  logic [AW-1:0]                       start_addr,
  input  logic [1:0]                          start_cmd,
  input  logic                                host_lock,
  input  logic [NDR-1:0]                      dr_pend,
  input  logic [NDR-1:0]                      dr_ready,
  input  logic [NDR*AW-1:0]                   dr_addr,
  input  logic [NDR*2-1:0]                    dr_cmd,
  input  logic [PW-1:0]                       post_free,
  input  logic                                phase,
  input  logic [AW-1:0]                       phase_addr,
  input  logic                                phase_write,
  input  logic                                phase_linear,
  output logic                                acc,
  output logic                                retry,
  output logic                                disc,
  output logic                                alloc,
  output logic [(NDR > 1 ? $clog2(NDR) : 1)-1:0] alloc_idx
);
  localparam int IW         = (NDR > 1) ? $clog2(NDR) : 1;
  localparam int LINE_WORDS = LINE_BYTES / BUS_BYTES;

  logic          hit_wait, hit_done, free_any;
  logic [IW-1:0] free_idx;
  why_e          why;
  logic          acc_n, retry_n, alloc_n;
  logic          eol, post_low, disc_n;

  dt_match #(.AW(AW), .NDR(NDR), .IW(IW)) u_match (
    .clk(clk), .rst_n(rst_n),
    .q_addr(start_addr), .q_cmd(start_cmd),
    .ent_pend(dr_pend), .ent_ready(dr_ready),
    .ent_addr(dr_addr), .ent_cmd(dr_cmd),
    .hit_wait(hit_wait), .hit_done(hit_done),
    .free_any(free_any), .free_idx(free_idx)
  );

  start_decide #(.PW(PW), .LINE_WORDS(LINE_WORDS)) u_start (
    .clk(clk), .rst_n(rst_n),
    .start(start), .lock(host_lock), .cmd(start_cmd), .post_free(post_free),
    .hit_wait(hit_wait), .hit_done(hit_done), .free_any(free_any),
    .why(why), .acc_n(acc_n), .retry_n(retry_n), .alloc_n(alloc_n)
  );

  phase_decide #(.AW(AW), .PW(PW), .LINE_BYTES(LINE_BYTES), .BUS_BYTES(BUS_BYTES)) u_phase (
    .phase(phase), .write(phase_write), .linear(phase_linear),
    .addr(phase_addr), .post_free(post_free),
    .eol(eol), .post_low(post_low), .disc_n(disc_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= 1'b0;
      retry     <= 1'b0;
      disc      <= 1'b0;
      alloc     <= 1'b0;
      alloc_idx <= '0;
    end else begin
      acc       <= acc_n;
      retry     <= retry_n;
      disc      <= disc_n;
      alloc     <= alloc_n;
      alloc_idx <= alloc_n ? free_idx : '0;
    end
  end

  p_one_resp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({acc, retry}));

  p_start_answered_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (acc || retry));

  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (!acc && !retry && !alloc));

  p_lock_retry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start && host_lock |=> (retry && !alloc));

  p_wait_retry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start && !host_lock && start_cmd == CMD_READ && hit_wait |=> (retry && !alloc));

  p_alloc_on_retry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> retry);

  p_winv_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start && !host_lock && start_cmd == CMD_WINV && int'(post_free) < LINE_WORDS |=> retry);

  p_read_nonlinear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    phase && !phase_write && !phase_linear |=> disc);

  p_write_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    phase && phase_write && post_low |=> disc);

  p_no_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !phase |=> !disc);

endmodule

// File: tb/tgt_resp_ctrl_test.sv
`timescale 1ns/1ps
module tgt_resp_ctrl_test;
  localparam int AW = 32, NDR = 4, PW = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, start, host_lock, phase, phase_write, phase_linear;
  logic [AW-1:0] start_addr, phase_addr;
  logic [1:0] start_cmd;
  logic [NDR-1:0] dr_pend, dr_ready;
  logic [NDR*AW-1:0] dr_addr;
  logic [NDR*2-1:0] dr_cmd;
  logic [PW-1:0] post_free;
  logic acc, retry, disc, alloc;
  logic [1:0] alloc_idx;

  tgt_resp_ctrl uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .start_cmd(start_cmd), .host_lock(host_lock), .dr_pend(dr_pend),
    .dr_ready(dr_ready), .dr_addr(dr_addr), .dr_cmd(dr_cmd),
    .post_free(post_free), .phase(phase), .phase_addr(phase_addr),
    .phase_write(phase_write), .phase_linear(phase_linear),
    .acc(acc), .retry(retry), .disc(disc), .alloc(alloc), .alloc_idx(alloc_idx)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ent_a(input int i);
    return 32'h1000_0000 + 32'(i * 64);
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int pfs[5] = '{0, 1, 15, 16, 17};
    int ppf[4] = '{0, 1, 2, 7};
    rst_n = 0; start = 1; host_lock = 0; start_cmd = 2'b01; start_addr = '0;
    dr_pend = '0; dr_ready = '0; dr_addr = '0; dr_cmd = '0; post_free = 8'd5;
    phase = 1; phase_addr = 32'h3000_0000; phase_write = 0; phase_linear = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset outputs", {28'd0, acc, retry, disc, alloc}, 32'd0);
    rst_n = 1; start = 0; phase = 0;
    step();
    chk("R1", "idle outputs", {28'd0, acc, retry, disc, alloc}, 32'd0);

    // first-phase sweep
    for (int lk = 0; lk < 2; lk++)
      for (int c = 0; c < 4; c++)
        for (int pi = 0; pi < 5; pi++)
          for (int pd = 0; pd < 16; pd++)
            for (int rd = 0; rd < 16; rd++)
              for (int tg = 0; tg < 5; tg++)
                for (int ms = 0; ms < 2; ms++) begin
                  bit hw, hd, e_acc, e_alloc;
                  int fi;
                  string req;
                  if (c != 0 && (rd != 0 || tg != 0 || ms != 0)) continue;
                  for (int i = 0; i < NDR; i++) begin
                    dr_addr[i*AW +: AW] = ent_a(i);
                    dr_cmd[i*2 +: 2] = (ms == 1 && i == tg) ? 2'b11 : 2'b00;
                  end
                  dr_pend = 4'(pd); dr_ready = 4'(rd);
                  host_lock = 1'(lk); start_cmd = 2'(c); post_free = 8'(pfs[pi]);
                  start_addr = (tg < 4) ? ent_a(tg) : 32'h2000_0040;
                  start = 1;
                  step();
                  hw = 0; hd = 0; fi = -1;
                  for (int i = 0; i < NDR; i++)
                    if (pd[i] && ent_a(i) == start_addr && dr_cmd[i*2 +: 2] == 2'(c)) begin
                      if (rd[i]) hd = 1; else hw = 1;
                    end
                  for (int i = NDR - 1; i >= 0; i--) if (!pd[i]) fi = i;
                  e_acc = 0; e_alloc = 0;
                  if (lk == 1) req = "R2";
                  else if (c == 0) begin
                    if (hw) req = "R3";
                    else if (hd) begin req = "R4"; e_acc = 1; end
                    else begin req = "R5"; e_alloc = (fi >= 0); end
                  end
                  else if (c == 2) begin req = "R7"; e_acc = (pfs[pi] >= 16); end
                  else begin req = "R6"; e_acc = (pfs[pi] >= 1); end
                  chk(req, "acc/retry/alloc", {29'd0, acc, retry, alloc},
                      {29'd0, e_acc, !e_acc, e_alloc});
                  if (e_alloc) chk("R5", "alloc_idx", {30'd0, alloc_idx}, 32'(fi));
                end
    start = 0;
    step();
    chk("R1", "no response without start", {29'd0, acc, retry, alloc}, 32'd0);

    // burst data-phase sweep
    for (int w = 0; w < 16; w++)
      for (int wr = 0; wr < 2; wr++)
        for (int ln = 0; ln < 2; ln++)
          for (int pi = 0; pi < 4; pi++) begin
            bit e;
            phase = 1; phase_write = 1'(wr); phase_linear = 1'(ln);
            phase_addr = 32'h3000_0040 + 32'(w * 4);
            post_free = 8'(ppf[pi]);
            step();
            if (wr == 1) e = (ppf[pi] <= 1) || (w == 15);
            else e = (ln == 0) || (w == 15);
            chk(wr ? "R9" : "R8", "disc", {31'd0, disc}, {31'd0, e});
          end
    phase = 0;
    step();
    chk("R9", "disc without phase", {31'd0, disc}, 32'd0);

    // asynchronous reset during activity
    start = 1; host_lock = 0; start_cmd = 2'b01; post_free = 8'd3; phase = 1;
    phase_write = 1; phase_addr = 32'h3000_007C;
    step();
    chk("R6", "write before reset", {30'd0, acc, retry}, 32'b10);
    rst_n = 0;
    #2;
    chk("R1", "async reset clears", {28'd0, acc, retry, disc, alloc}, 32'd0);
    @(negedge clk);
    rst_n = 1; start = 0; phase = 0;
    step();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule